// File: doc/BRIEF.md
# Ones-Count Adaptive Sequential Multiplier

This block multiplies two unsigned 16-bit operands and picks its method by looking at the multiplier operand first. When that operand holds three or fewer set bits, the product is assembled from a handful of shifted copies of the multiplicand, one addition per clock, in high-to-low (Horner) order. A denser operand is cut into two 8-bit halves. A sparse half contributes one shifted copy of the multiplicand per set bit. A dense half is recoded into radix-4 signed digits, and only the digits that are non-zero take an adder cycle.

Rows that carry nothing never reach the adder, and the accumulator register is not clocked in cycles without a row. A caller pulses `start` with both operands. It waits for the one-cycle `done` pulse and then reads `product` and the two status fields, which say which method was used.

Top module: `oamul_top`

## Requirements
- R1: When `done` is high, `product` equals the exact 32-bit unsigned product of the `mcand` and `mplier` values captured on the accepted `start` edge.
- R2: A multiplier with at most three set bits gives `path` = 0. `category` is 0 for no set bits. For one set bit it is 1 if bit 0 is that bit, otherwise 2. For two set bits it is 3 if bit 0 is among them, otherwise 4. For three set bits it is 5 if bit 0 is among them, otherwise 6.
- R3: A multiplier with four or more set bits gives `category` = 7. `path` is then 1 when neither 8-bit half has more than three set bits, 2 when exactly one half does, and 3 when both halves do.
- R4: With `path` = 0, `done` rises max(1, ones) clock edges after the edge that accepts `start`. A zero multiplier finishes in one cycle with a product of zero.
- R5: With a split operand, the cycle count is the sum over the two halves. A sparse half counts its set bits. A dense half counts its non-zero radix-4 digits over five digit positions: the triples (h[2g+1], h[2g], h[2g-1]) with h[-1] = 0 and h[8] = h[9] = 0, where each digit has the value -2*h[2g+1] + h[2g] + h[2g-1].
- R6: `done` is a single-cycle pulse. `product` changes only in the cycle `done` rises. `path` and `category` change only when a new `start` is accepted. A `start` raised while a product is being formed is ignored.
- R7: During and right after reset, `done`, `product`, `path` and `category` are all zero.
- R8: Multiplying 65 by 34 gives 2210 with `path` = 0 and `category` = 4, in two cycles (one load and one addition).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a multiplication; accepted only while idle |
| mcand | input | 16 | Multiplicand, captured with `start` |
| mplier | input | 16 | Multiplier, inspected and captured with `start` |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 32 | Unsigned product, held until the next completion |
| path | output | 2 | Method used: 0 sparse, 1 split all shift-add, 2 split one recoded half, 3 split both halves recoded |
| category | output | 3 | Bit-pattern class of the multiplier, 7 for split operands |

## Verification
A wrong pending-row mask or digit register shows up as a wrong `product` on the very next `done`. It also shows up as a `done` that comes earlier or later than the cycle count the operand predicts, so checking the latency exactly catches rows that were dropped or repeated. A bad Horner shift or a bad digit sign corrupts only operands that use that method. For this reason the stimulus mixes sparse operands, split operands with one or two dense halves, and all-ones operands. A misclassification is visible as soon as `done` rises, because `path` and `category` are compared against a model of the counting rules.

// File: rtl/oamul_pkg.sv
package oamul_pkg;

  typedef enum logic [1:0] {
    PATH_SPARSE    = 2'd0,
    PATH_SPLIT_SA  = 2'd1,
    PATH_SPLIT_ONE = 2'd2,
    PATH_SPLIT_TWO = 2'd3
  } path_e;

  typedef enum logic [2:0] {
    CAT_ZERO      = 3'd0,
    CAT_ONE_LSB   = 3'd1,
    CAT_ONE_HI    = 3'd2,
    CAT_TWO_LSB   = 3'd3,
    CAT_TWO_HI    = 3'd4,
    CAT_THREE_LSB = 3'd5,
    CAT_THREE_HI  = 3'd6,
    CAT_SPLIT     = 3'd7
  } cat_e;

  // signed digit stored as {negative, magnitude two, magnitude one}
  localparam int DIG_NEG = 2;
  localparam int DIG_TWO = 1;
  localparam int DIG_ONE = 0;

  function automatic int unsigned ones_in(input logic [63:0] v);
    int unsigned cnt;
    cnt = 0;
    for (int i = 0; i < 64; i++) cnt = cnt + 32'(v[i]);
    return cnt;
  endfunction

endpackage

// File: rtl/oamul_classify.sv
module oamul_classify
  import oamul_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int SPARSE_MAX = 3,
  localparam int HALF      = WIDTH / 2
) (
  input  logic [WIDTH-1:0] mplier,
  output logic             sparse,
  output logic             booth_lo,
  output logic             booth_hi,
  output path_e            path,
  output cat_e             cat
);

  int unsigned n_all, n_lo, n_hi;

  always_comb begin
    n_all    = ones_in(64'(mplier));
    n_lo     = ones_in(64'(mplier[HALF-1:0]));
    n_hi     = ones_in(64'(mplier[WIDTH-1:HALF]));
    sparse   = (n_all <= SPARSE_MAX);
    booth_lo = !sparse && (n_lo > SPARSE_MAX);
    booth_hi = !sparse && (n_hi > SPARSE_MAX);

    if (sparse) begin
      path = PATH_SPARSE;
    end else begin
      case ({booth_hi, booth_lo})
        2'b00:   path = PATH_SPLIT_SA;
        2'b11:   path = PATH_SPLIT_TWO;
        default: path = PATH_SPLIT_ONE;
      endcase
    end

    if (!sparse) begin
      cat = CAT_SPLIT;
    end else begin
      case (n_all)
        0:       cat = CAT_ZERO;
        1:       cat = mplier[0] ? CAT_ONE_LSB : CAT_ONE_HI;
        2:       cat = mplier[0] ? CAT_TWO_LSB : CAT_TWO_HI;
        default: cat = mplier[0] ? CAT_THREE_LSB : CAT_THREE_HI;
      endcase
    end
  end

endmodule

// File: rtl/oamul_booth_rec.sv
module oamul_booth_rec
  import oamul_pkg::*;
#(
  parameter int HALF  = 8,
  localparam int NDIG = HALF / 2 + 1
) (
  input  logic [HALF-1:0]       half_in,
  output logic [NDIG-1:0][2:0]  digit,
  output logic [NDIG-1:0]       nz
);

  logic [HALF+2:0] ext;
  assign ext = {2'b00, half_in, 1'b0};

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic b_up, b_mid, b_dn;
    assign b_up  = ext[2*g+2];
    assign b_mid = ext[2*g+1];
    assign b_dn  = ext[2*g];
    assign digit[g][DIG_NEG] = b_up & ~(b_mid & b_dn);
    assign digit[g][DIG_TWO] = (b_up & ~b_mid & ~b_dn) | (~b_up & b_mid & b_dn);
    assign digit[g][DIG_ONE] = b_mid ^ b_dn;
    assign nz[g] = digit[g][DIG_TWO] | digit[g][DIG_ONE];
  end

endmodule

// File: rtl/oamul_pick.sv
module oamul_pick #(
  parameter int N         = 16,
  parameter bit MSB_FIRST = 1'b0,
  localparam int IW       = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  if (MSB_FIRST) begin : g_msb
    always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = 0; i < N; i++) begin
        if (req[i]) begin
          found = 1'b1;
          idx   = IW'(i);
        end
      end
    end
  end else begin : g_lsb
    always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
        if (req[i]) begin
          found = 1'b1;
          idx   = IW'(i);
        end
      end
    end
  end

endmodule

// File: rtl/oamul_top.sv
module oamul_top
  import oamul_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int SPARSE_MAX = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               done,
  output logic [2*WIDTH-1:0] product,
  output logic [1:0]         path,
  output logic [2:0]         category
);

  localparam int HALF  = WIDTH / 2;
  localparam int NDIG  = HALF / 2 + 1;
  localparam int NITEM = 2 * NDIG;
  localparam int PW    = 2 * WIDTH;
  localparam int IW    = $clog2(WIDTH);
  localparam int DW    = $clog2(NITEM);
  localparam int SW    = $clog2(PW);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  // operand inspection on the incoming multiplier
  logic  cls_sparse, cls_booth_lo, cls_booth_hi;
  path_e cls_path;
  cat_e  cls_cat;

  oamul_classify #(.WIDTH(WIDTH), .SPARSE_MAX(SPARSE_MAX)) u_classify (
    .mplier   (mplier),
    .sparse   (cls_sparse),
    .booth_lo (cls_booth_lo),
    .booth_hi (cls_booth_hi),
    .path     (cls_path),
    .cat      (cls_cat)
  );

  logic [NDIG-1:0][2:0] dig_lo, dig_hi;
  logic [NDIG-1:0]      nz_lo, nz_hi;

  oamul_booth_rec #(.HALF(HALF)) u_rec_lo (
    .half_in (mplier[HALF-1:0]),
    .digit   (dig_lo),
    .nz      (nz_lo)
  );

  oamul_booth_rec #(.HALF(HALF)) u_rec_hi (
    .half_in (mplier[WIDTH-1:HALF]),
    .digit   (dig_hi),
    .nz      (nz_hi)
  );

  // state
  logic                  busy_q, done_q, sparse_q;
  logic [WIDTH-1:0]      mcand_q;
  logic [WIDTH-1:0]      sa_pend_q;
  logic [NITEM-1:0]      bd_pend_q;
  logic [NITEM-1:0][2:0] bd_dig_q;
  logic [PW-1:0]         acc_q, prod_q;
  logic [IW-1:0]         prev_q;
  path_e                 path_q;
  cat_e                  cat_q;

  // row selection
  logic          hi_found, lo_found, bd_found;
  logic [IW-1:0] hi_idx, lo_idx;
  logic [DW-1:0] bd_idx;

  oamul_pick #(.N(WIDTH), .MSB_FIRST(1'b1)) u_pick_hi (
    .req (sa_pend_q), .found (hi_found), .idx (hi_idx)
  );
  oamul_pick #(.N(WIDTH), .MSB_FIRST(1'b0)) u_pick_lo (
    .req (sa_pend_q), .found (lo_found), .idx (lo_idx)
  );
  oamul_pick #(.N(NITEM), .MSB_FIRST(1'b0)) u_pick_bd (
    .req (bd_pend_q), .found (bd_found), .idx (bd_idx)
  );

  // one addition per cycle
  logic [PW-1:0]    mc_ext, acc_step, mag, term, fin;
  logic [WIDTH-1:0] clr_sa;
  logic [NITEM-1:0] clr_bd;
  logic [IW-1:0]    gap;
  logic [DW-1:0]    dig_pos;
  logic             upper, step_take;
  logic [2:0]       cur_dig;
  logic [SW-1:0]    bshift;

  assign mc_ext = PW'(mcand_q);
  assign gap    = prev_q - hi_idx;

  always_comb begin
    step_take = 1'b0;
    acc_step  = acc_q;
    clr_sa    = '0;
    clr_bd    = '0;
    upper     = 1'b0;
    dig_pos   = bd_idx;
    cur_dig   = bd_dig_q[bd_idx];
    mag       = mc_ext;
    term      = '0;
    bshift    = '0;
    if (sparse_q) begin
      if (hi_found) begin
        step_take      = 1'b1;
        acc_step       = (acc_q << gap) + mc_ext;
        clr_sa[hi_idx] = 1'b1;
      end
    end else if (lo_found) begin
      step_take      = 1'b1;
      acc_step       = acc_q + (mc_ext << lo_idx);
      clr_sa[lo_idx] = 1'b1;
    end else if (bd_found) begin
      step_take = 1'b1;
      if (bd_idx >= DW'(NDIG)) begin
        upper   = 1'b1;
        dig_pos = bd_idx - DW'(NDIG);
      end
      mag      = cur_dig[DIG_TWO] ? (mc_ext << 1) : mc_ext;
      bshift   = SW'(2 * int'(dig_pos) + (upper ? HALF : 0));
      term     = mag << bshift;
      acc_step = cur_dig[DIG_NEG] ? (acc_q - term) : (acc_q + term);
      clr_bd[bd_idx] = 1'b1;
    end
  end

  assign fin = sparse_q ? (acc_step << hi_idx) : acc_step;

  // next state
  logic             accept, last;
  logic             busy_d, done_d, acc_en, prev_en, fin_en;
  logic [WIDTH-1:0] sa_pend_n, sa_pend_d;
  logic [NITEM-1:0] bd_pend_n, bd_pend_d;
  logic [PW-1:0]    acc_d;

  assign accept    = start && !busy_q;
  assign sa_pend_n = sa_pend_q & ~clr_sa;
  assign bd_pend_n = bd_pend_q & ~clr_bd;
  assign last      = (sa_pend_n == '0) && (bd_pend_n == '0);

  always_comb begin
    busy_d    = busy_q;
    done_d    = 1'b0;
    acc_en    = 1'b0;
    prev_en   = 1'b0;
    fin_en    = 1'b0;
    acc_d     = acc_step;
    sa_pend_d = sa_pend_n;
    bd_pend_d = bd_pend_n;
    if (accept) begin
      busy_d    = 1'b1;
      acc_en    = 1'b1;
      prev_en   = 1'b1;
      acc_d     = '0;
      sa_pend_d = cls_sparse ? mplier :
                  {cls_booth_hi ? {HALF{1'b0}} : mplier[WIDTH-1:HALF],
                   cls_booth_lo ? {HALF{1'b0}} : mplier[HALF-1:0]};
      bd_pend_d = {cls_booth_hi ? nz_hi : {NDIG{1'b0}},
                   cls_booth_lo ? nz_lo : {NDIG{1'b0}}};
    end else if (busy_q) begin
      acc_en  = step_take;
      prev_en = sparse_q && step_take;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        fin_en = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      sparse_q  <= 1'b0;
      mcand_q   <= '0;
      sa_pend_q <= '0;
      bd_pend_q <= '0;
      bd_dig_q  <= '0;
      acc_q     <= '0;
      prev_q    <= '0;
      prod_q    <= '0;
      path_q    <= PATH_SPARSE;
      cat_q     <= CAT_ZERO;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (accept) begin
        sparse_q <= cls_sparse;
        mcand_q  <= mcand;
        bd_dig_q <= {dig_hi, dig_lo};
        path_q   <= cls_path;
        cat_q    <= cls_cat;
      end
      if (accept || busy_q) begin
        sa_pend_q <= sa_pend_d;
        bd_pend_q <= bd_pend_d;
      end
      if (acc_en)  acc_q  <= acc_d;
      if (prev_en) prev_q <= accept ? '0 : hi_idx;
      if (fin_en)  prod_q <= fin;
    end
  end

  assign done     = done_q;
  assign product  = prod_q;
  assign path     = path_q;
  assign category = cat_q;

endmodule

// File: rtl/oamul_chk.sv
module oamul_chk #(
  parameter int WIDTH = 16
) (
  input logic               clk,
  input logic               rst_ni,
  input logic               start,
  input logic               busy_q,
  input logic               done,
  input logic [WIDTH-1:0]   mcand,
  input logic [WIDTH-1:0]   mplier,
  input logic [2*WIDTH-1:0] product,
  input logic [2*WIDTH-1:0] acc_q,
  input logic [1:0]         path,
  input logic [2:0]         category
);

  localparam int PW        = 2 * WIDTH;
  localparam int MAX_STEPS = 2 * (WIDTH / 4 + 1);

  logic [WIDTH-1:0] a_q, b_q;
  logic [7:0]       run_cnt_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q       <= '0;
      b_q       <= '0;
      run_cnt_q <= '0;
    end else begin
      if (start && !busy_q) begin
        a_q       <= mcand;
        b_q       <= mplier;
        run_cnt_q <= '0;
      end else if (busy_q) begin
        run_cnt_q <= run_cnt_q + 8'd1;
      end
    end
  end

  // R1
  product_match_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> (product == PW'(a_q) * PW'(b_q)));

  // R2
  sparse_cat_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && path == 2'd0) |-> (category != 3'd7));

  // R3
  split_cat_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && path != 2'd0) |-> (category == 3'd7));

  // R5
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_q |-> (run_cnt_q < 8'(MAX_STEPS)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);

  // R6
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(product) |-> done);

  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_q |=> ($stable(path) && $stable(category)));

  // R6
  acc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy_q && !start) |=> $stable(acc_q));

endmodule

bind oamul_top oamul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_ni   (rst_ni),
  .start    (start),
  .busy_q   (busy_q),
  .done     (done),
  .mcand    (mcand),
  .mplier   (mplier),
  .product  (product),
  .acc_q    (acc_q),
  .path     (path),
  .category (category)
);

// File: tb/oamul_top_tb_top.sv
module oamul_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] mcand, mplier;
  logic        done;
  logic [31:0] product;
  logic [1:0]  path;
  logic [2:0]  category;

  int n_chk = 0;
  int n_bad = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  oamul_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mcand    (mcand),
    .mplier   (mplier),
    .done     (done),
    .product  (product),
    .path     (path),
    .category (category)
  );

  function automatic int pc(input logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic int rec_rows(input logic [7:0] h);
    logic [10:0] e;
    int c = 0;
    e = {2'b00, h, 1'b0};
    for (int g = 0; g < 5; g++) begin
      int v;
      v = -2 * int'(e[2*g+2]) + int'(e[2*g+1]) + int'(e[2*g]);
      if (v != 0) c++;
    end
    return c;
  endfunction

  function automatic int exp_path(input logic [15:0] b);
    int lo, hi;
    if (pc(b) <= 3) return 0;
    lo = (pc({8'h00, b[7:0]}) > 3) ? 1 : 0;
    hi = (pc({8'h00, b[15:8]}) > 3) ? 1 : 0;
    return 1 + lo + hi;
  endfunction

  function automatic int exp_cat(input logic [15:0] b);
    case (pc(b))
      0: return 0;
      1: return b[0] ? 1 : 2;
      2: return b[0] ? 3 : 4;
      3: return b[0] ? 5 : 6;
      default: return 7;
    endcase
  endfunction

  function automatic int exp_steps(input logic [15:0] b);
    int s = 0;
    if (pc(b) <= 3) return (pc(b) == 0) ? 1 : pc(b);
    for (int h = 0; h < 2; h++) begin
      logic [7:0] hv;
      hv = (h == 0) ? b[7:0] : b[15:8];
      s += (pc({8'h00, hv}) <= 3) ? pc({8'h00, hv}) : rec_rows(hv);
    end
    return s;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] a, input logic [15:0] b, input bit poke);
    int steps;
    bit got;
    logic [31:0] held;
    @(negedge clk);
    start  = 1'b1;
    mcand  = a;
    mplier = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    steps = 0;
    got   = 1'b0;
    while (!got && steps < 64) begin
      @(posedge clk);
      @(negedge clk);
      steps++;
      if (done) got = 1'b1;
      else if (poke && steps == 1) begin
        start  = 1'b1;
        mcand  = ~a;
        mplier = ~b;
      end else if (poke && steps == 2) start = 1'b0;
    end
    start = 1'b0;
    if (!got) check("R4 done never rose", 64'(steps), 64'(exp_steps(b)));
    check(poke ? "R6 busy start ignored, product" : "R1 product",
          64'(product), 64'(32'(a) * 32'(b)));
    check(exp_path(b) == 0 ? "R2 path" : "R3 path", 64'(path), 64'(exp_path(b)));
    check(exp_cat(b) == 7 ? "R3 category" : "R2 category", 64'(category), 64'(exp_cat(b)));
    check(exp_path(b) == 0 ? "R4 latency" : "R5 latency", 64'(steps), 64'(exp_steps(b)));
    held = product;
    @(negedge clk);
    check("R6 done single pulse", 64'(done), 64'(0));
    check("R6 product held", 64'(product), 64'(held));
  endtask

  function automatic logic [7:0] sparse8();
    logic [7:0] v = '0;
    int k;
    k = int'($urandom % 4);
    for (int i = 0; i < k; i++) v[$urandom % 8] = 1'b1;
    return v;
  endfunction

  function automatic logic [15:0] sparse16();
    logic [15:0] v = '0;
    int k;
    k = int'($urandom % 4);
    for (int i = 0; i < k; i++) v[$urandom % 16] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] ra, rb;
    void'($urandom(32'h5eed_0a11));
    rst_n  = 1'b0;
    start  = 1'b0;
    mcand  = '0;
    mplier = '0;
    repeat (3) @(negedge clk);
    check("R7 reset done", 64'(done), 64'(0));
    check("R7 reset product", 64'(product), 64'(0));
    check("R7 reset path", 64'(path), 64'(0));
    check("R7 reset category", 64'(category), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 after release done", 64'(done), 64'(0));

    // R8: 65 x 34
    run_op(16'd65, 16'd34, 1'b0);
    check("R8 product 2210", 64'(product), 64'd2210);
    check("R8 category two bits", 64'(category), 64'd4);

    // R4 zero multiplier, R2 edge positions
    run_op(16'h1234, 16'h0000, 1'b0);
    run_op(16'h0000, 16'hFFFF, 1'b0);
    run_op(16'hABCD, 16'h0001, 1'b0);
    run_op(16'hABCD, 16'h8000, 1'b0);
    run_op(16'hFFFF, 16'h8001, 1'b0);
    run_op(16'hFFFF, 16'hC000, 1'b0);
    run_op(16'hFFFF, 16'h8003, 1'b0);
    run_op(16'hFFFF, 16'hE000, 1'b0);
    run_op(16'h2AC9, 16'h0029, 1'b0);
    // R3/R5 split variants
    run_op(16'hFFFF, 16'hFFFF, 1'b0);
    run_op(16'h7531, 16'h000F, 1'b0);
    run_op(16'h7531, 16'hF000, 1'b0);
    run_op(16'h9999, 16'h0707, 1'b0);
    run_op(16'hFFFF, 16'h80FF, 1'b0);
    run_op(16'h1357, 16'h5555, 1'b0);
    run_op(16'h8001, 16'hAAAA, 1'b0);
    // R6 start while busy
    run_op(16'hBEEF, 16'hFFFF, 1'b1);
    run_op(16'h1234, 16'h5A5A, 1'b1);

    for (int n = 0; n < 400; n++) begin
      ra = 16'($urandom);
      case ($urandom % 4)
        0: rb = 16'($urandom);
        1: rb = sparse16();
        2: rb = {8'($urandom), sparse8()};
        default: rb = {sparse8(), 8'($urandom)};
      endcase
      run_op(ra, rb, (n % 17 == 0) && exp_steps(rb) >= 3);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule